// File: doc/BRIEF.md
# Disk Drive Select and Control Latches

This block is a small set of bus-mapped latches that generate the control lines for a pair of floppy ports. Each clock edge closes one bus cycle. The address and read/write level present at that edge decide whether a latch is set, cleared or left alone. The same 32-byte address span can do one thing on a read and another on a write.

The block takes the drive-2 enable from the disk controller and passes it to one of two active-low outputs: an external-port enable or an internal-drive enable. A latched route bit picks the output. The output that is not picked is held high. The block also drives a head-select level, an active-low 3.5-inch drive select, and a sticky controller-reset output.

The active-low reset may be held for long stretches. All latches stay at their reset values for as long as it is held.

Top module: `dsk_ctl_latch`

## Requirements
- R1: A read (rnw=1) at any address from 0xCE40 to 0xCE5F clears head_sel to 0 at the closing clock edge.
- R2: A read at any address from 0xCE60 to 0xCE7F sets head_sel to 1 at the closing clock edge.
- R3: A write (rnw=0) at any address from 0xCE40 to 0xCE5F drives sel35_n low at the closing clock edge. head_sel is left unchanged.
- R4: A write at any address from 0xCE60 to 0xCE7F drives sel35_n high at the closing clock edge.
- R5: A write at exactly 0xCC80 selects the internal route. From then on, int_en_n equals drv2_en_n and ext_en_n is 1.
- R6: A write at exactly 0xCCC0 selects the external route. From then on, ext_en_n equals drv2_en_n and int_en_n is 1.
- R7: While rst_n is 0, and after its release until the first decoded access, the outputs have these values: external route, head_sel=0, sel35_n=1, ctl_reset=0. Accesses made during reset have no effect.
- R8: A write at exactly 0xCC40 sets ctl_reset to 1. It stays 1 until rst_n is asserted.
- R9: ext_en_n and int_en_n are never both 0.
- R10: An access outside the decoded cases leaves every latch unchanged. This includes reads at 0xCC40, 0xCC80 and 0xCCC0, and any access at 0xCE80 or 0xCE20. sel35_n is not changed by reads. head_sel is not changed by writes.
- R11: The route and controller-reset addresses need a full 16-bit match. A write at 0xCC81 or 0xCCBF changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge closes one bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset, may be held long |
| addr | input | 16 | Bus address |
| rnw | input | 1 | 1 = read, 0 = write |
| drv2_en_n | input | 1 | Drive-2 enable from the disk controller, active low |
| ext_en_n | output | 1 | External-port drive enable, active low |
| int_en_n | output | 1 | Internal-drive enable, active low |
| head_sel | output | 1 | Head-select level |
| sel35_n | output | 1 | 3.5-inch drive select, active low |
| ctl_reset | output | 1 | Latched controller-reset output |

## Verification
Head-select and drive-select windows are hit at their first and last addresses with both read and write directions. This separates the read action from the write action and catches an off-by-one window edge. Route commands are followed by toggling drv2_en_n, so a wrong route, a leak onto the unselected output, or a stale latch all appear at the ports. Near-miss addresses and wrong-direction accesses confirm that the decode is exact. Reset is asserted mid-run while accesses keep arriving, to show that the latches hold for the whole reset period.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int ADDR_W = 16;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic head_sel;
    logic sel35_n;
    logic route_int;
    logic ctl_reset;
  } latch_t;

  typedef struct packed {
    logic hds_clr;
    logic hds_set;
    logic d35_on;
    logic d35_off;
    logic rt_int;
    logic rt_ext;
    logic ctl_set;
  } strobe_t;

  localparam latch_t LATCH_RST = '{head_sel: 1'b0, sel35_n: 1'b1,
                                   route_int: 1'b0, ctl_reset: 1'b0};

  // True when a lies in the aligned span of 2**lg bytes starting at base.
  function automatic logic in_span(addr_t a, addr_t base, int lg);
    return (a >> lg) == (base >> lg);
  endfunction

  // Route steering: returns {ext_n, int_n}; the unpicked side idles high.
  function automatic logic [1:0] steer(logic to_int, logic en_n);
    return to_int ? {1'b1, en_n} : {en_n, 1'b1};
  endfunction
endpackage

// File: rtl/dsk_decode.sv
module dsk_decode
  import dsk_pkg::*;
#(
  parameter addr_t HDS_CLR_BASE = 16'hCE40,
  parameter addr_t HDS_SET_BASE = 16'hCE60,
  parameter int    SPAN_LG      = 5,
  parameter addr_t RT_INT_ADDR  = 16'hCC80,
  parameter addr_t RT_EXT_ADDR  = 16'hCCC0,
  parameter addr_t CTL_ADDR     = 16'hCC40
) (
  input  addr_t   addr,
  input  logic    rnw,
  output strobe_t stb,
  output logic    any_hit
);
  logic clr_win, set_win;

  always_comb begin
    clr_win     = in_span(addr, HDS_CLR_BASE, SPAN_LG);
    set_win     = in_span(addr, HDS_SET_BASE, SPAN_LG);
    stb.hds_clr = clr_win & rnw;
    stb.hds_set = set_win & rnw;
    stb.d35_on  = clr_win & ~rnw;
    stb.d35_off = set_win & ~rnw;
    stb.rt_int  = (addr == RT_INT_ADDR) & ~rnw;
    stb.rt_ext  = (addr == RT_EXT_ADDR) & ~rnw;
    stb.ctl_set = (addr == CTL_ADDR) & ~rnw;
    any_hit     = |stb;
  end
endmodule

// File: rtl/dsk_latches.sv
module dsk_latches
  import dsk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t stb,
  input  logic    any_hit,
  output latch_t  q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= LATCH_RST;
    end else begin
      if (stb.hds_clr) q.head_sel <= 1'b0;
      if (stb.hds_set) q.head_sel <= 1'b1;
      if (stb.d35_on)  q.sel35_n  <= 1'b0;
      if (stb.d35_off) q.sel35_n  <= 1'b1;
      if (stb.rt_int)  q.route_int <= 1'b1;
      if (stb.rt_ext)  q.route_int <= 1'b0;
      if (stb.ctl_set) q.ctl_reset <= 1'b1;
    end
  end

  AST_HDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    stb.hds_clr |=> !q.head_sel); // R1
  AST_HDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stb.hds_set |=> q.head_sel); // R2
  AST_D35_ON: assert property (@(posedge clk) disable iff (!rst_n)
    stb.d35_on |=> (!q.sel35_n && $stable(q.head_sel))); // R3
  AST_D35_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    stb.d35_off |=> q.sel35_n); // R4
  AST_RT_INT: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rt_int |=> q.route_int); // R5
  AST_RT_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rt_ext |=> !q.route_int); // R6
  AST_CTL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    q.ctl_reset |=> q.ctl_reset); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |=> $stable(q)); // R10
endmodule

// File: rtl/dsk_steer.sv
module dsk_steer
  import dsk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic route_int,
  input  logic drv2_en_n,
  output logic ext_en_n,
  output logic int_en_n
);
  always_comb {ext_en_n, int_en_n} = steer(route_int, drv2_en_n);

  AST_NO_DUAL_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~ext_en_n, ~int_en_n})); // R9
endmodule

// File: rtl/dsk_ctl_latch.sv
module dsk_ctl_latch
  import dsk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        rnw,
  input  logic        drv2_en_n,
  output logic        ext_en_n,
  output logic        int_en_n,
  output logic        head_sel,
  output logic        sel35_n,
  output logic        ctl_reset
);
  strobe_t stb;
  logic    any_hit;
  latch_t  q;

  dsk_decode u_dec (.addr(addr), .rnw(rnw), .stb(stb), .any_hit(any_hit));

  dsk_latches u_lat (.clk(clk), .rst_n(rst_n), .stb(stb),
                     .any_hit(any_hit), .q(q));

  dsk_steer u_str (.clk(clk), .rst_n(rst_n), .route_int(q.route_int),
                   .drv2_en_n(drv2_en_n), .ext_en_n(ext_en_n),
                   .int_en_n(int_en_n));

  assign head_sel  = q.head_sel;
  assign sel35_n   = q.sel35_n;
  assign ctl_reset = q.ctl_reset;
endmodule

// File: tb/dsk_ctl_latch_test.sv
`timescale 1ns/1ps
module dsk_ctl_latch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rnw = 1'b1;
  logic        drv2_en_n = 1'b1;
  logic        ext_en_n, int_en_n, head_sel, sel35_n, ctl_reset;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dsk_ctl_latch uut (.clk(clk), .rst_n(rst_n), .addr(addr), .rnw(rnw),
    .drv2_en_n(drv2_en_n), .ext_en_n(ext_en_n), .int_en_n(int_en_n),
    .head_sel(head_sel), .sel35_n(sel35_n), .ctl_reset(ctl_reset));

  typedef struct {
    logic [4:0] v;   // {ext_n, int_n, head_sel, sel35_n, ctl_reset}
    string      tag;
  } exp_t;
  exp_t sb[$];

  // reference state
  logic m_hs = 1'b0, m_d35n = 1'b1, m_int = 1'b0, m_ctl = 1'b0;

  task automatic access(input logic [15:0] a, input logic rd,
                        input logic d2, input logic rst_v, input string tag);
    exp_t e;
    @(negedge clk); #1;
    addr = a; rnw = rd; drv2_en_n = d2; rst_n = rst_v;
    @(posedge clk); #0.5;
    if (!rst_v) begin
      m_hs = 1'b0; m_d35n = 1'b1; m_int = 1'b0; m_ctl = 1'b0;
    end else begin
      if (rd && a >= 16'hCE40 && a <= 16'hCE5F) m_hs = 1'b0;
      if (rd && a >= 16'hCE60 && a <= 16'hCE7F) m_hs = 1'b1;
      if (!rd && a >= 16'hCE40 && a <= 16'hCE5F) m_d35n = 1'b0;
      if (!rd && a >= 16'hCE60 && a <= 16'hCE7F) m_d35n = 1'b1;
      if (!rd && a == 16'hCC80) m_int = 1'b1;
      if (!rd && a == 16'hCCC0) m_int = 1'b0;
      if (!rd && a == 16'hCC40) m_ctl = 1'b1;
    end
    e.v[4] = m_int ? 1'b1 : d2;
    e.v[3] = m_int ? d2 : 1'b1;
    e.v[2] = m_hs;
    e.v[1] = m_d35n;
    e.v[0] = m_ctl;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares at the falling edge after each closing edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        logic [4:0] act;
        e = sb.pop_front();
        act = {ext_en_n, int_en_n, head_sel, sel35_n, ctl_reset};
        total++;
        if (act !== e.v) begin
          bad++;
          $display("FAIL %s: actual=%b expected=%b (ext,int,hs,s35,ctl)",
                   e.tag, act, e.v);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R7: accesses under reset do nothing
    access(16'hCE60, 1'b1, 1'b0, 1'b0, "R7");
    access(16'hCE40, 1'b0, 1'b0, 1'b0, "R7");
    access(16'hCC80, 1'b0, 1'b0, 1'b0, "R7");
    access(16'hCC40, 1'b0, 1'b1, 1'b0, "R7");
    access(16'h0000, 1'b1, 1'b0, 1'b1, "R7");
    // R2 / R1 window edges
    access(16'hCE60, 1'b1, 1'b1, 1'b1, "R2");
    access(16'hCE40, 1'b1, 1'b1, 1'b1, "R1");
    access(16'hCE7F, 1'b1, 1'b1, 1'b1, "R2");
    access(16'hCE5F, 1'b1, 1'b1, 1'b1, "R1");
    access(16'hCE61, 1'b1, 1'b1, 1'b1, "R2");
    // R3 / R4 (head_sel stays 1 through writes)
    access(16'hCE40, 1'b0, 1'b1, 1'b1, "R3");
    access(16'hCE7F, 1'b0, 1'b1, 1'b1, "R4");
    access(16'hCE5F, 1'b0, 1'b1, 1'b1, "R3");
    // R10: reads leave sel35_n alone, wrong ranges do nothing
    access(16'hCE60, 1'b1, 1'b1, 1'b1, "R10");
    access(16'hCE80, 1'b0, 1'b1, 1'b1, "R10");
    access(16'hCE20, 1'b1, 1'b1, 1'b1, "R10");
    access(16'hCE3F, 1'b0, 1'b1, 1'b1, "R10");
    access(16'hCC80, 1'b1, 1'b0, 1'b1, "R10");
    // R5 / R9 internal route, drv2 toggling
    access(16'hCC80, 1'b0, 1'b0, 1'b1, "R5");
    access(16'h1234, 1'b1, 1'b1, 1'b1, "R9");
    access(16'h1234, 1'b1, 1'b0, 1'b1, "R9");
    access(16'hCCC0, 1'b1, 1'b0, 1'b1, "R10");
    // R11 near-miss addresses
    access(16'hCCC1, 1'b0, 1'b0, 1'b1, "R11");
    access(16'hCCBF, 1'b0, 1'b0, 1'b1, "R11");
    // R6 external route
    access(16'hCCC0, 1'b0, 1'b0, 1'b1, "R6");
    access(16'hCC81, 1'b0, 1'b0, 1'b1, "R11");
    access(16'h0000, 1'b1, 1'b1, 1'b1, "R6");
    // R8 controller reset, R10 read doesn't set
    access(16'hCC40, 1'b1, 1'b1, 1'b1, "R10");
    access(16'hCC41, 1'b0, 1'b1, 1'b1, "R11");
    access(16'hCC40, 1'b0, 1'b1, 1'b1, "R8");
    access(16'hCE60, 1'b0, 1'b1, 1'b1, "R8");
    access(16'hCCC0, 1'b0, 1'b0, 1'b1, "R8");
    access(16'hCC80, 1'b0, 1'b0, 1'b1, "R5");
    // R7 long reset mid-run with accesses arriving
    for (int i = 0; i < 20; i++)
      access(16'hCE40 + 16'(i), i[0], i[1], 1'b0, "R7");
    access(16'h0000, 1'b1, 1'b0, 1'b1, "R7");
    access(16'hCC80, 1'b0, 1'b0, 1'b1, "R5");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule